// File: doc/BRIEF.md
# Periodic Comparator Timer Channel

This block is one comparator channel of a multi-channel event timer. It watches a free-running 64-bit main count that is shared by all channels and produced elsewhere. When the count reaches the channel's comparator, the channel sends a single interrupt pulse. The channel runs either one-shot or periodic. It can also work at a 32-bit width, where only the low halves of the count and the comparator take part in the compare. In periodic mode a separate period register moves the comparator forward after every match. The period is added once per cycle, with wrap-around, until the comparator is ahead of the count again.

The register access unit outside this block does the address decode and merges partial writes. It then presents whole 64-bit values on `wr_data` with a strobe for the configuration register or for the comparator. The channel returns the configuration image and the comparator for readback.

Interrupts go out on a one-hot vector of 32 lines. Normally the line is the route field, but only when the channel's read-only capability mask allows that route. When legacy replacement is on, channel 0 uses fixed line 0 and channel 1 uses fixed line 8. Channel 0 in that mode also holds a suppress output high for the legacy interval timer.

Top module: `cmp_timer_channel`

## Requirements
- R1: After reset the comparator reads all ones. The configuration image reads the capability mask in bits 63:32, ones in bits 4 and 5 (periodic and 32-bit capable), and zero everywhere else. No interrupt line is active and `route_err` is low.
- R2: A comparator write loads the comparator when the periodic bit (config bit 3) is clear or the set-value bit (config bit 6) is set. Otherwise it loads the period register and leaves the comparator unchanged.
- R3: Every comparator write clears the set-value bit.
- R4: With the narrow-mode bit (config bit 8) set:
  - comparator writes keep only their low 32 bits;
  - writing the configuration with bit 8 set zeroes the stored comparator's upper half at once;
  - the compare and the periodic addition use only the low 32 bits, with wrap-around.
- R5: The channel is armed by its effective enable rising, and by any comparator write while enabled. An armed channel whose comparator minus count (signed, at the active width) is not positive fires. This includes firing at once when it is already behind. A one-shot channel fires once per arming.
- R6: In periodic mode with a nonzero period, a match fires one pulse. The period is then added to the comparator, once per cycle, until the comparator is strictly ahead of the count.
- R7: The channel fires only while both the global enable input and the timer enable (config bit 2) are high. Dropping either one stops all pulses.
- R8: Without legacy replacement, a pulse appears on line `route`, where route is config bits 13:9. This happens only when bit `route` of the capability mask is set.
- R9: A match on a route the capability mask forbids drives no line and sets `route_err`. `route_err` stays set until reset.
- R10: With legacy replacement on, channel 0 pulses line 0 and channel 1 pulses line 8, whatever the route field holds. Channel 0 drives `pit_suppress` high while it is enabled in legacy mode. Other channels never do.
- R11: Each interrupt is a one-cycle pulse on at most one line. Two pulses are never on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_cnt | input | 64 | Shared free-running main count |
| glb_en | input | 1 | Global timer enable |
| legacy_en | input | 1 | Legacy replacement routing enable |
| cfg_wr | input | 1 | Write strobe for the configuration register |
| cmp_wr | input | 1 | Write strobe for the comparator/period register |
| wr_data | input | 64 | Merged 64-bit write value |
| cfg_rd | output | 64 | Configuration readback image |
| cmp_rd | output | 64 | Comparator readback |
| irq_out | output | 32 | One-hot interrupt pulse lines |
| pit_suppress | output | 1 | Silences legacy interval timer channel 0 |
| route_err | output | 1 | Sticky forbidden-route flag |

## Verification
The assertions assume the access unit never raises `cfg_wr` and `cmp_wr` in the same cycle. The bench drives the two strobes only through separate one-cycle write tasks, so they never overlap.

The no-back-to-back-pulse property also assumes that each catch-up sequence ends within a few cycles. The stimulus therefore holds `main_cnt` steady while a match is resolved and uses periods of at least two. Inputs change one nanosecond after each rising edge, so no property sees a change at the sampling edge.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    localparam int REG_W        = 64;
    localparam int HALF_W       = 32;
    localparam int RT_W         = 5;
    localparam int NUM_LINES    = 1 << RT_W;

    localparam int BIT_ENABLE   = 2;
    localparam int BIT_PERIODIC = 3;
    localparam int BIT_PER_CAP  = 4;
    localparam int BIT_W32_CAP  = 5;
    localparam int BIT_SETVAL   = 6;
    localparam int BIT_W32      = 8;
    localparam int BIT_RT_LSB   = 9;

    typedef struct packed {
        logic [RT_W-1:0] route;
        logic            w32;
        logic            setval;
        logic            periodic;
        logic            enable;
    } tmr_cfg_t;

    function automatic logic [REG_W-1:0] cfg_image(tmr_cfg_t c, logic [HALF_W-1:0] cap);
        logic [REG_W-1:0] img;
        img                            = '0;
        img[REG_W-1:HALF_W]            = cap;
        img[BIT_ENABLE]                = c.enable;
        img[BIT_PERIODIC]              = c.periodic;
        img[BIT_PER_CAP]               = 1'b1;
        img[BIT_W32_CAP]               = 1'b1;
        img[BIT_SETVAL]                = c.setval;
        img[BIT_W32]                   = c.w32;
        img[BIT_RT_LSB +: RT_W]        = c.route;
        return img;
    endfunction

    // True when the comparator lies strictly ahead of the count at the active width.
    function automatic logic cmp_ahead(logic [REG_W-1:0] cmp, logic [REG_W-1:0] cnt, logic w32);
        logic [REG_W-1:0]  d64;
        logic [HALF_W-1:0] d32;
        d64 = cmp - cnt;
        d32 = cmp[HALF_W-1:0] - cnt[HALF_W-1:0];
        if (w32) return !d32[HALF_W-1] && (d32 != '0);
        else     return !d64[REG_W-1]  && (d64 != '0);
    endfunction

endpackage

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cmp_wr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             adv,
    output tmr_cfg_t         cfg,
    output logic [REG_W-1:0] cmp,
    output logic [REG_W-1:0] per
);
    tmr_cfg_t         cfg_q;
    logic [REG_W-1:0] cmp_q, per_q, wval, cmp_next_adv;

    always_comb begin
        wval = cfg_q.w32 ? {{(REG_W-HALF_W){1'b0}}, wr_data[HALF_W-1:0]} : wr_data;
        if (cfg_q.w32)
            cmp_next_adv = {{(REG_W-HALF_W){1'b0}}, cmp_q[HALF_W-1:0] + per_q[HALF_W-1:0]};
        else
            cmp_next_adv = cmp_q + per_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            cmp_q <= '1;
            per_q <= '0;
        end else if (cfg_wr) begin
            cfg_q.enable   <= wr_data[BIT_ENABLE];
            cfg_q.periodic <= wr_data[BIT_PERIODIC];
            cfg_q.setval   <= wr_data[BIT_SETVAL];
            cfg_q.w32      <= wr_data[BIT_W32];
            cfg_q.route    <= wr_data[BIT_RT_LSB +: RT_W];
            if (wr_data[BIT_W32])
                cmp_q <= {{(REG_W-HALF_W){1'b0}}, cmp_q[HALF_W-1:0]};
        end else if (cmp_wr) begin
            if (!cfg_q.periodic || cfg_q.setval) cmp_q <= wval;
            else                                 per_q <= wval;
            cfg_q.setval <= 1'b0;
        end else if (adv) begin
            cmp_q <= cmp_next_adv;
        end
    end

    assign cfg = cfg_q;
    assign cmp = cmp_q;
    assign per = per_q;
endmodule

// File: rtl/tmr_chan_seq.sv
module tmr_chan_seq
    import tmr_chan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             glb_en,
    input  tmr_cfg_t         cfg,
    input  logic [REG_W-1:0] cmp,
    input  logic [REG_W-1:0] per,
    input  logic [REG_W-1:0] main_cnt,
    input  logic             cfg_wr,
    input  logic             cmp_wr,
    output logic             fire,
    output logic             adv
);
    logic en, en_q, armed_q, catch_q, behind, busy, repeat_ok;

    always_comb begin
        en        = glb_en && cfg.enable;
        busy      = cfg_wr || cmp_wr;
        behind    = !cmp_ahead(cmp, main_cnt, cfg.w32);
        repeat_ok = cfg.periodic && (per != '0);
        fire      = en && armed_q && !busy && behind && !catch_q;
        adv       = en && armed_q && !busy && behind && repeat_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            armed_q <= 1'b0;
            catch_q <= 1'b0;
        end else begin
            en_q <= en;
            if (!en) begin
                armed_q <= 1'b0;
                catch_q <= 1'b0;
            end else if (cmp_wr || !en_q) begin
                armed_q <= 1'b1;
                catch_q <= 1'b0;
            end else if (cfg_wr) begin
                armed_q <= armed_q;
            end else if (armed_q && behind) begin
                if (repeat_ok) catch_q <= 1'b1;
                else           armed_q <= 1'b0;
            end else if (armed_q) begin
                catch_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_chan_irq.sv
module tmr_chan_irq
    import tmr_chan_pkg::*;
#(
    parameter int              CH_INDEX  = 0,
    parameter logic [HALF_W-1:0] ROUTE_CAP = 32'h00FF_00FF
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fire,
    input  logic                 legacy_en,
    input  logic [RT_W-1:0]      route,
    output logic [NUM_LINES-1:0] irq_out,
    output logic                 route_err
);
    localparam logic [RT_W-1:0] LEG_LINE = (CH_INDEX == 0) ? RT_W'(0) : RT_W'(8);
    localparam logic            HAS_LEG  = (CH_INDEX < 2);

    logic [NUM_LINES-1:0] irq_q;
    logic                 err_q;
    logic                 use_leg;

    assign use_leg = HAS_LEG && legacy_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= '0;
            err_q <= 1'b0;
        end else begin
            irq_q <= '0;
            if (fire) begin
                if (use_leg)               irq_q[LEG_LINE] <= 1'b1;
                else if (ROUTE_CAP[route]) irq_q[route]    <= 1'b1;
                else                       err_q           <= 1'b1;
            end
        end
    end

    assign irq_out   = irq_q;
    assign route_err = err_q;
endmodule

// File: rtl/cmp_timer_channel.sv
module cmp_timer_channel
    import tmr_chan_pkg::*;
#(
    parameter int              CH_INDEX  = 0,
    parameter logic [31:0]     ROUTE_CAP = 32'h00FF_00FF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] main_cnt,
    input  logic        glb_en,
    input  logic        legacy_en,
    input  logic        cfg_wr,
    input  logic        cmp_wr,
    input  logic [63:0] wr_data,
    output logic [63:0] cfg_rd,
    output logic [63:0] cmp_rd,
    output logic [31:0] irq_out,
    output logic        pit_suppress,
    output logic        route_err
);
    tmr_cfg_t         cfg;
    logic [REG_W-1:0] cmp, per;
    logic             fire, adv;

    tmr_chan_regs u_regs (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cmp_wr(cmp_wr),
        .wr_data(wr_data), .adv(adv), .cfg(cfg), .cmp(cmp), .per(per)
    );

    tmr_chan_seq u_seq (
        .clk(clk), .rst(rst), .glb_en(glb_en), .cfg(cfg), .cmp(cmp), .per(per),
        .main_cnt(main_cnt), .cfg_wr(cfg_wr), .cmp_wr(cmp_wr),
        .fire(fire), .adv(adv)
    );

    tmr_chan_irq #(.CH_INDEX(CH_INDEX), .ROUTE_CAP(ROUTE_CAP)) u_irq (
        .clk(clk), .rst(rst), .fire(fire), .legacy_en(legacy_en),
        .route(cfg.route), .irq_out(irq_out), .route_err(route_err)
    );

    assign cfg_rd       = cfg_image(cfg, ROUTE_CAP);
    assign cmp_rd       = cmp;
    assign pit_suppress = (CH_INDEX == 0) && legacy_en && glb_en && cfg.enable;
endmodule

// File: rtl/cmp_timer_channel_chk.sv
module cmp_timer_channel_chk #(
    parameter int CH_INDEX = 0
) (
    input logic        clk,
    input logic        rst,
    input logic        glb_en,
    input logic        legacy_en,
    input logic        cfg_wr,
    input logic        cmp_wr,
    input logic [63:0] cfg_rd,
    input logic [63:0] cmp_rd,
    input logic [31:0] irq_out,
    input logic        route_err,
    input logic        fire
);
    a_r11_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_out));

    a_r11_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (irq_out != '0) |=> (irq_out == '0));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        route_err |=> route_err);

    a_r3_setval_clears: assert property (@(posedge clk) disable iff (rst)
        (cmp_wr && !cfg_wr) |=> !cfg_rd[6]);

    a_r4_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rd[8] |-> (cmp_rd[63:32] == 32'h0));

    a_r7_gated: assert property (@(posedge clk) disable iff (rst)
        !glb_en |=> (irq_out == '0));

    generate
        if (CH_INDEX < 2) begin : g_leg
            localparam int LEG = (CH_INDEX == 0) ? 0 : 8;
            a_r10_legacy_line: assert property (@(posedge clk) disable iff (rst)
                (fire && legacy_en) |=> (irq_out == (32'h1 << LEG)));
        end
    endgenerate
endmodule

bind cmp_timer_channel cmp_timer_channel_chk #(.CH_INDEX(CH_INDEX)) u_chk (
    .clk(clk), .rst(rst), .glb_en(glb_en), .legacy_en(legacy_en),
    .cfg_wr(cfg_wr), .cmp_wr(cmp_wr), .cfg_rd(cfg_rd), .cmp_rd(cmp_rd),
    .irq_out(irq_out), .route_err(route_err), .fire(fire)
);

// File: tb/tb_cmp_timer_channel.sv
`timescale 1ns/1ps
module tb_cmp_timer_channel;
    localparam logic [31:0] CAP = 32'h00FF_00FF;
    localparam logic [63:0] EN  = 64'h4;
    localparam logic [63:0] PER = 64'h8;
    localparam logic [63:0] SV  = 64'h40;
    localparam logic [63:0] W32 = 64'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] main_cnt = '0;
    logic        glb_en = 1'b0, legacy_en = 1'b0, cfg_wr = 1'b0, cmp_wr = 1'b0;
    logic [63:0] wr_data = '0;
    logic [63:0] cfg_rd, cmp_rd, cfg_rd1, cmp_rd1;
    logic [31:0] irq_out, irq_out1;
    logic        pit_suppress, route_err, pit_suppress1, route_err1;

    int n_chk = 0, n_fail = 0;
    int hits[32];
    int total = 0, hits1_8 = 0, viol = 0;
    logic prev_any = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cmp_timer_channel #(.CH_INDEX(0), .ROUTE_CAP(CAP)) dut (
        .clk(clk), .rst(rst), .main_cnt(main_cnt), .glb_en(glb_en), .legacy_en(legacy_en),
        .cfg_wr(cfg_wr), .cmp_wr(cmp_wr), .wr_data(wr_data), .cfg_rd(cfg_rd), .cmp_rd(cmp_rd),
        .irq_out(irq_out), .pit_suppress(pit_suppress), .route_err(route_err));

    cmp_timer_channel #(.CH_INDEX(1), .ROUTE_CAP(CAP)) dut1 (
        .clk(clk), .rst(rst), .main_cnt(main_cnt), .glb_en(glb_en), .legacy_en(legacy_en),
        .cfg_wr(cfg_wr), .cmp_wr(cmp_wr), .wr_data(wr_data), .cfg_rd(cfg_rd1), .cmp_rd(cmp_rd1),
        .irq_out(irq_out1), .pit_suppress(pit_suppress1), .route_err(route_err1));

    // Pulse monitor, sampled mid-cycle (R11 checks shape)
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 32; i++) if (irq_out[i]) hits[i]++;
            if (irq_out != '0) total++;
            if ($countones(irq_out) > 1) viol++;
            if (prev_any && (irq_out != '0)) viol++;
            prev_any = (irq_out != '0);
            if (irq_out1[8]) hits1_8++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic clr();
        for (int i = 0; i < 32; i++) hits[i] = 0;
        total = 0;
        hits1_8 = 0;
    endtask

    task automatic wcfg(input logic [63:0] d);
        cfg_wr = 1'b1; wr_data = d; cyc(1); cfg_wr = 1'b0;
    endtask

    task automatic wcmp(input logic [63:0] d);
        cmp_wr = 1'b1; wr_data = d; cyc(1); cmp_wr = 1'b0;
    endtask

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] rt(input int r);
        return 64'(r) << 9;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R1 reset state
        check(cfg_rd == {CAP, 32'h30}, "R1 cfg image", cfg_rd, {CAP, 32'h30});
        check(cmp_rd == '1, "R1 comparator", cmp_rd, '1);
        check(irq_out == '0 && !route_err, "R1 outputs", {irq_out, 31'b0, route_err}, 64'h0);

        // R2 steering, R3 set-value self-clear
        wcmp(64'h1234);
        check(cmp_rd == 64'h1234, "R2 one-shot write to comparator", cmp_rd, 64'h1234);
        wcfg(PER);
        wcmp(64'd99);
        check(cmp_rd == 64'h1234, "R2 periodic write to period", cmp_rd, 64'h1234);
        wcfg(PER | SV);
        check(cfg_rd[6] == 1'b1, "R3 set-value readback", cfg_rd, cfg_rd | SV);
        wcmp(64'd77);
        check(cmp_rd == 64'd77, "R2 set-value write to comparator", cmp_rd, 64'd77);
        check(cfg_rd[6] == 1'b0, "R3 set-value cleared", cfg_rd, cfg_rd & ~SV);

        // R4 narrow mode truncation
        wcfg(64'h0);
        wcmp(64'hAAAA_BBBB_CCCC_DDDD);
        check(cmp_rd == 64'hAAAA_BBBB_CCCC_DDDD, "R4 wide write", cmp_rd, 64'hAAAA_BBBB_CCCC_DDDD);
        wcfg(W32);
        check(cmp_rd == 64'hCCCC_DDDD, "R4 truncate on mode set", cmp_rd, 64'hCCCC_DDDD);
        wcmp(64'h1111_2222_3333_4444);
        check(cmp_rd == 64'h3333_4444, "R4 truncated write", cmp_rd, 64'h3333_4444);

        // R5/R8 one-shot match on route 5
        wcfg(rt(5));
        wcmp(64'd150);
        main_cnt = 64'd100;
        glb_en = 1'b1;
        clr();
        wcfg(rt(5) | EN);
        cyc(10);
        check(total == 0, "R5 no fire while ahead", 64'(total), 64'd0);
        main_cnt = 64'd150;
        cyc(4);
        check(hits[5] == 1 && total == 1, "R8 pulse on route 5", 64'(hits[5]), 64'd1);
        cyc(10);
        check(total == 1, "R5 one-shot fires once", 64'(total), 64'd1);

        // R5 immediate fire when armed behind
        clr();
        wcmp(64'd50);
        cyc(3);
        check(hits[5] == 1, "R5 immediate fire on rearm", 64'(hits[5]), 64'd1);

        // R7 gating, then enable rise arms
        glb_en = 1'b0;
        clr();
        wcmp(64'd40);
        cyc(6);
        check(total == 0, "R7 no fire with global enable low", 64'(total), 64'd0);
        glb_en = 1'b1;
        cyc(4);
        check(hits[5] == 1, "R7/R5 fire after enable rise", 64'(hits[5]), 64'd1);

        // R6 periodic catch-up
        wcfg(rt(5) | PER | SV);
        wcmp(64'd1000);
        wcmp(64'd100);
        main_cnt = 64'd1005;
        clr();
        wcfg(rt(5) | PER | EN);
        cyc(6);
        check(hits[5] == 1, "R6 first periodic pulse", 64'(hits[5]), 64'd1);
        check(cmp_rd == 64'd1100, "R6 single advance", cmp_rd, 64'd1100);
        main_cnt = 64'd1350;
        cyc(8);
        check(hits[5] == 2, "R6 one pulse per catch-up", 64'(hits[5]), 64'd2);
        check(cmp_rd == 64'd1400, "R6 multi-step advance", cmp_rd, 64'd1400);

        // R4 narrow periodic wrap and low-half compare
        wcfg(rt(5) | PER | SV | W32);
        wcmp(64'hFFFF_FFF0);
        wcmp(64'h20);
        main_cnt = 64'h5_FFFF_FFF8;
        clr();
        wcfg(rt(5) | PER | W32 | EN);
        cyc(6);
        check(hits[5] == 1, "R4 narrow match", 64'(hits[5]), 64'd1);
        check(cmp_rd == 64'h10, "R4 wrapped advance", cmp_rd, 64'h10);
        main_cnt = 64'h7_0000_0008;
        cyc(6);
        check(hits[5] == 1, "R4 upper count bits ignored", 64'(hits[5]), 64'd1);

        // R9 forbidden route
        wcfg(64'h0);
        clr();
        wcfg(rt(10) | EN);
        wcmp(64'h0);
        cyc(4);
        check(total == 0, "R9 no line driven", 64'(total), 64'd0);
        check(route_err == 1'b1, "R9 error set", 64'(route_err), 64'd1);
        cyc(4);
        check(route_err == 1'b1, "R9 error sticky", 64'(route_err), 64'd1);

        // R10 legacy routing
        legacy_en = 1'b1;
        cyc(1);
        check(pit_suppress == 1'b1, "R10 suppress ch0", 64'(pit_suppress), 64'd1);
        check(pit_suppress1 == 1'b0, "R10 no suppress ch1", 64'(pit_suppress1), 64'd0);
        clr();
        wcmp(64'h0);
        cyc(4);
        check(hits[0] == 1 && total == 1, "R10 ch0 line 0", 64'(hits[0]), 64'd1);
        check(hits1_8 == 1, "R10 ch1 line 8", 64'(hits1_8), 64'd1);

        // R11 pulse shape over the whole run
        check(viol == 0, "R11 one-hot single-cycle pulses", 64'(viol), 64'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule